// File: doc/BRIEF.md
# Prioritised Interrupt Claim Controller

This block collects interrupt requests from a set of level-sensitive sources and hands each one to exactly one of several service contexts. A context is one hart running in one privilege level (machine or supervisor). Every source has a programmable priority, where zero means "never" and larger numbers mean more urgent. Every context has its own per-source enable mask and a priority threshold. Each context has one interrupt request output.

Software talks to the block through a simple word-wide register bus. Reading a context's claim/complete word returns the winning source ID and takes that source at the same time. A claimed source loses its pending flag and is no longer offered to any context. Its gateway then ignores the source line until software writes the same ID back to the claim/complete word as a completion. After that, a line that is still high raises a new pending request.

Address map (byte offsets, word aligned, `addr_i[1:0]` must be zero):
- priority of source `k` at `4*k`, for k = 1..NUM_SRC;
- enable mask of context `c` at `0x100 + 4*c`, where bit `k` enables source `k` and bit 0 reads as zero;
- threshold of context `c` at `0x200 + 8*c`, and its claim/complete word at `0x204 + 8*c`.

Top module: `irq_claim_ctrl`

## Requirements
- R1: A source whose priority register holds 0 never drives a context's interrupt output and is never returned by a claim read.
- R2: A claim read returns the ID of the pending, enabled source with the largest priority. Among sources of equal priority, the one with the lowest ID wins.
- R3: Source ID 0 is reserved. A claim read returns 0 when the context has no eligible pending source.
- R4: A claim read clears the returned source's pending flag. From the next cycle on, that source is offered to no context: other contexts' claim reads skip it, and their interrupt outputs drop if it was their only candidate.
- R5: While a source is claimed and not yet completed, new activity on its line sets no pending flag. Once its ID is completed, a line that is still high sets the pending flag again one cycle later.
- R6: `irq_o[c]` is high only while the winning priority for context c is strictly greater than that context's threshold.
- R7: A completion write is ignored if the written ID is not enabled in that context's mask. The source stays blocked.
- R8: The enable masks are kept per context. A source pending for one context's mask is invisible to a context whose mask has that bit clear.
- R9: Priority, enable and threshold registers read back what was written. Enable bit 0 always reads 0. Read data appears on `rdata_o` with `rvalid_o` high in the cycle after the request.
- R10: After reset, all priorities, masks and thresholds are 0, every `irq_o` bit is low, and every claim read returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Source request lines; bit k-1 is source ID k |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 32 | Read data |
| irq_o | output | NUM_CTX | Interrupt request per context |

## Verification
The assertions assume the bus carries at most one access per cycle. Under that assumption, at most one source is claimed per cycle, and a claim and a completion never reach the same gateway together. They also assume that software completes an ID only after claiming it. The bench drives one access per clock and changes source lines and bus fields only on the falling edge. It completes only IDs it has claimed, except for the deliberately rejected completion in the R7 case.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    RGN_PRIO = 2'd0,
    RGN_EN   = 2'd1,
    RGN_CTX  = 2'd2,
    RGN_RSVD = 2'd3
  } rgn_e;
endpackage

// File: rtl/intc_gateway.sv
module intc_gateway #(
  parameter int NUM_SRC = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] claim_i,
  input  logic [NUM_SRC-1:0] comp_i,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] pend_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (claim_i[i]) begin
          pend_q[i] <= 1'b0;
          act_q[i]  <= 1'b1;
        end else begin
          if (comp_i[i]) act_q[i] <= 1'b0;
          // blocked sources do not re-pend until completion
          if (src_i[i] && !pend_q[i] && !act_q[i]) pend_q[i] <= 1'b1;
        end
      end
    end
  end

  assign pend_o = pend_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    AST_CLAIM_CLEARS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      claim_i[g] |=> !pend_q[g]); // R4
    AST_CLAIM_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      claim_i[g] |-> pend_q[g]); // R4
    AST_BLOCKED_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_q[g] && !comp_i[g]) |=> !pend_q[g]); // R5
  end
endmodule

// File: rtl/intc_target.sv
module intc_target #(
  parameter int NUM_SRC = 7,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_SRC-1:0]             pend_i,
  input  logic [NUM_SRC-1:0]             en_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]              thr_i,
  output logic [ID_W-1:0]                best_id_o,
  output logic                           irq_o
);
  logic [PRIO_W-1:0] best_p;

  // strict compare: zero priority never wins, ties keep the lower ID
  always_comb begin
    best_p    = '0;
    best_id_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && en_i[i] && (prio_i[i] > best_p)) begin
        best_p    = prio_i[i];
        best_id_o = ID_W'(i + 1);
      end
    end
  end

  assign irq_o = best_p > thr_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    AST_WINNER_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (best_id_o == ID_W'(g + 1)) |-> (pend_i[g] && en_i[g] && prio_i[g] != '0)); // R1
  end
endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int ADDR_W  = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic               rvalid_o,
  output logic [31:0]        rdata_o,
  output logic [NUM_CTX-1:0] irq_o
);
  localparam int ID_W   = $clog2(NUM_SRC + 1);
  localparam int IDX_W  = ADDR_W - 4;
  localparam int CIDX_W = IDX_W - 1;

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_CTX-1:0][NUM_SRC-1:0] en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0]  thr_q;
  logic [NUM_CTX-1:0][ID_W-1:0]    best_id;
  logic [NUM_SRC-1:0] pend, claim_vec, comp_vec;
  logic [31:0] rd_next;

  rgn_e              rgn;
  logic [IDX_W-1:0]  idx;
  logic [CIDX_W-1:0] cidx;
  logic              sel_claim, aligned, rd, wr;

  assign rgn       = rgn_e'(addr_i[ADDR_W-1:ADDR_W-2]);
  assign idx       = addr_i[ADDR_W-3:2];
  assign cidx      = addr_i[ADDR_W-3:3];
  assign sel_claim = addr_i[2];
  assign aligned   = addr_i[1:0] == 2'b00;
  assign rd        = req_i && !we_i && aligned;
  assign wr        = req_i && we_i && aligned;

  intc_gateway #(.NUM_SRC(NUM_SRC)) u_gw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .claim_i(claim_vec),
    .comp_i (comp_vec),
    .pend_o (pend)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    intc_target #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_tgt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pend_i   (pend),
      .en_i     (en_q[c]),
      .prio_i   (prio_q),
      .thr_i    (thr_q[c]),
      .best_id_o(best_id[c]),
      .irq_o    (irq_o[c])
    );

    AST_IRQ_HAS_WINNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (best_id[c] != '0)); // R6
  end

  // claim on read, complete on write of the claim word
  always_comb begin
    claim_vec = '0;
    comp_vec  = '0;
    for (int c = 0; c < NUM_CTX; c++) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (rd && rgn == RGN_CTX && cidx == CIDX_W'(c) && sel_claim &&
            best_id[c] == ID_W'(i + 1))
          claim_vec[i] = 1'b1;
        if (wr && rgn == RGN_CTX && cidx == CIDX_W'(c) && sel_claim &&
            wdata_i == 32'(i + 1) && en_q[c][i])
          comp_vec[i] = 1'b1;
      end
    end
  end

  always_comb begin
    rd_next = '0;
    unique case (rgn)
      RGN_PRIO:
        for (int i = 0; i < NUM_SRC; i++)
          if (idx == IDX_W'(i + 1)) rd_next = 32'(prio_q[i]);
      RGN_EN:
        for (int c = 0; c < NUM_CTX; c++)
          if (idx == IDX_W'(c)) rd_next = 32'({en_q[c], 1'b0});
      RGN_CTX:
        for (int c = 0; c < NUM_CTX; c++)
          if (cidx == CIDX_W'(c))
            rd_next = sel_claim ? 32'(best_id[c]) : 32'(thr_q[c]);
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= req_i && !we_i;
      if (req_i && !we_i) rdata_o <= aligned ? rd_next : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++)
        if (wr && rgn == RGN_PRIO && idx == IDX_W'(i + 1))
          prio_q[i] <= wdata_i[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      thr_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CTX; c++) begin
        if (wr && rgn == RGN_EN && idx == IDX_W'(c))
          en_q[c] <= wdata_i[NUM_SRC:1];
        if (wr && rgn == RGN_CTX && cidx == CIDX_W'(c) && !sel_claim)
          thr_q[c] <= wdata_i[PRIO_W-1:0];
      end
    end
  end

  AST_ONE_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_vec)); // R4
  AST_NO_CLAIM_AND_COMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_vec & comp_vec) == '0); // R5
endmodule

// File: tb/irq_claim_ctrl_test.sv
module irq_claim_ctrl_test;
  localparam int NUM_SRC = 7;
  localparam int NUM_CTX = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_SRC-1:0] src = '0;
  logic req = 1'b0, we = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rvalid;
  logic [31:0] rdata;
  logic [NUM_CTX-1:0] irq;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_claim_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [9:0] a_prio(int id); return 10'(4 * id); endfunction
  function automatic logic [9:0] a_en(int c);    return 10'(256 + 4 * c); endfunction
  function automatic logic [9:0] a_thr(int c);   return 10'(512 + 8 * c); endfunction
  function automatic logic [9:0] a_clm(int c);   return 10'(516 + 8 * c); endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    if (rvalid !== 1'b1) chk("R9 rvalid", 32'(rvalid), 32'd1);
    d = rdata;
  endtask

  task automatic set_src(int id, logic v);
    @(negedge clk);
    src[id-1] = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R10 irq after reset", 32'(irq), 32'd0);
    rd(a_clm(0), d); chk("R10 claim ctx0 after reset", d, 0);
    rd(a_clm(1), d); chk("R3 claim ctx1 empty", d, 0);
    rd(a_prio(4), d); chk("R10 prio reset", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(a_prio(3), 5); rd(a_prio(3), d); chk("R9 prio readback", d, 5);
    wr(a_en(1), 32'hFF); rd(a_en(1), d); chk("R9 enable bit0 reads 0", d, 32'hFE);
    wr(a_thr(1), 6); rd(a_thr(1), d); chk("R9 threshold readback", d, 6);
    wr(a_thr(1), 0); wr(a_en(1), 0);
  endtask

  task automatic t_prio_zero();
    logic [31:0] d;
    wr(a_en(0), 32'hFE);
    wr(a_prio(2), 0);
    set_src(2, 1'b1);
    chk("R1 zero prio no irq", 32'(irq[0]), 0);
    rd(a_clm(0), d); chk("R1 zero prio not claimed", d, 0);
    set_src(2, 1'b0);
    wr(a_prio(2), 1);
    rd(a_clm(0), d); chk("R1 claim after prio raised", d, 2);
    wr(a_clm(0), 2);
  endtask

  task automatic t_select();
    logic [31:0] d;
    wr(a_prio(1), 3); wr(a_prio(3), 5); wr(a_prio(5), 5); wr(a_prio(6), 2);
    @(negedge clk);
    src = 7'b0110101;
    @(negedge clk);
    chk("R6 irq with thr 0", 32'(irq[0]), 1);
    rd(a_clm(0), d); chk("R2 tie lowest id", d, 3);
    rd(a_clm(0), d); chk("R2 next highest", d, 5);
    rd(a_clm(0), d); chk("R2 middle prio", d, 1);
    rd(a_clm(0), d); chk("R2 lowest prio", d, 6);
    rd(a_clm(0), d); chk("R3 none left", d, 0);
    chk("R4 irq drops after claims", 32'(irq[0]), 0);
    @(negedge clk); src = '0;
    wr(a_clm(0), 3); wr(a_clm(0), 5); wr(a_clm(0), 1); wr(a_clm(0), 6);
  endtask

  task automatic t_threshold();
    logic [31:0] d;
    wr(a_prio(4), 3); wr(a_thr(0), 3);
    set_src(4, 1'b1);
    chk("R6 equal to threshold no irq", 32'(irq[0]), 0);
    wr(a_thr(0), 2);
    chk("R6 above threshold irq", 32'(irq[0]), 1);
    set_src(4, 1'b0);
    rd(a_clm(0), d); chk("R6 claim id", d, 4);
    wr(a_clm(0), 4); wr(a_thr(0), 0);
  endtask

  task automatic t_context();
    logic [31:0] d;
    wr(a_en(0), 32'h02); wr(a_en(1), 32'h0A); wr(a_prio(3), 2);
    @(negedge clk); src = 7'b0000101;
    @(negedge clk);
    chk("R8 both contexts requested", 32'(irq), 3);
    rd(a_clm(1), d); chk("R2 ctx1 claims 1", d, 1);
    chk("R4 ctx0 irq drops", 32'(irq[0]), 0);
    rd(a_clm(0), d); chk("R4 ctx0 not offered", d, 0);
    chk("R8 ctx1 still has src3", 32'(irq[1]), 1);
    rd(a_clm(1), d); chk("R8 ctx1 claims 3", d, 3);
    @(negedge clk); src[2] = 1'b0;
  endtask

  task automatic t_block();
    logic [31:0] d;
    set_src(1, 1'b0); set_src(1, 1'b1);
    rd(a_clm(1), d); chk("R5 blocked source ignored", d, 0);
    wr(a_clm(1), 3);
    wr(a_en(0), 0);
    wr(a_clm(0), 1);
    @(negedge clk);
    rd(a_clm(1), d); chk("R7 rejected completion keeps block", d, 0);
    wr(a_clm(1), 1);
    @(negedge clk);
    chk("R5 level re-pends after completion", 32'(irq[1]), 1);
    rd(a_clm(1), d); chk("R5 reclaim", d, 1);
    set_src(1, 1'b0);
    wr(a_clm(1), 1);
    rd(a_clm(1), d); chk("R3 empty at end", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_prio_zero();
    t_select();
    t_threshold();
    t_context();
    t_block();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule